// File: doc/BRIEF.md
# Low-Frequency Clock Source Selector

This block builds a 32.768 kHz timebase for a low-power clock domain. All of its logic runs on a free-running 48 MHz ring-oscillator clock. The timebase can come from one of three sources: a single-ended suspend clock pin, the output of a crystal oscillator, or a tick derived from the 48 MHz clock by fractional division. Two configuration inputs choose which external source is preferred. These inputs are held by battery-backed logic outside the block, so a main-supply reset does not change them.

Each external pin has its own activity detector. When the preferred pin has not shown a steady run of edges, or goes quiet, the selector uses the derived tick until the pin is healthy again. A change of source waits for the next tick of the source in use, and a hold-off window keeps strobes from bunching together. Downstream logic receives a one-cycle tick strobe, a square wave with 50% duty, a 2-bit code for the source in use, and a flag that reports the timebase as accurate once it has been stable for 100 µs.

Top module: `lfclk_select`

## Requirements
- R1: Source code `src_o` is 00 for the derived tick, 01 for the suspend pin, 10 for the crystal, and never 11. With `cfg_en32k`=0 the derived tick is used. With `cfg_en32k`=1, `cfg_xtal_sel`=1 selects the crystal and `cfg_xtal_sel`=0 selects the suspend pin. The selected external pin is used only while it is present; otherwise the code falls back to 00.
- R2: An external pin becomes present after four synchronized rising edges, each arriving less than 2048 clock cycles after the previous one. Edges spaced wider than that never make the pin present.
- R3: A present pin that shows no rising edge for 2048 cycles becomes missing. If that pin is in use, the source code returns to 00 within a few cycles.
- R4: On the derived source, consecutive ticks are 1464 or 1465 cycles apart. This comes from a phase step of 32768 against a modulus of 48,000,000.
- R5: `tick_o` is high for one cycle at a time, and two ticks are never fewer than 733 cycles apart, including across source changes.
- R6: `level_o` rises together with each tick and stays high for exactly 732 cycles.
- R7: `ready_o` is 0 after reset and clears in the same cycle as any change of `src_o`. It rises 4800 cycles (±1) after reset release or after the last change, provided the source does not change in between.
- R8: A change between live sources happens in the cycle in which the outgoing source delivers a tick, so `tick_o` is 1 in the cycle where `src_o` first shows the new code.
- R9: On an external source, a tick follows each rising edge of that pin, so the tick spacing equals the pin period.
- R10: During reset, `tick_o`, `level_o`, `ready_o` and `src_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz ring-oscillator clock |
| rst_n | input | 1 | Active-low main-supply reset |
| cfg_en32k | input | 1 | 1 enables use of an external source |
| cfg_xtal_sel | input | 1 | With `cfg_en32k`=1: 1 selects the crystal, 0 selects the suspend pin |
| susclk_in | input | 1 | Asynchronous single-ended 32.768 kHz suspend clock |
| xtal_in | input | 1 | Asynchronous crystal oscillator output |
| tick_o | output | 1 | One-cycle strobe per 32.768 kHz period |
| level_o | output | 1 | 50%-duty square wave aligned to the tick |
| src_o | output | 2 | Source in use (00 derived, 01 suspend pin, 10 crystal) |
| ready_o | output | 1 | Timebase accurate |

## Verification
The bench drives a suspend clock whose edges are too far apart to count, and expects the selector to stay on the derived tick. A detector that ignored the spacing window would switch to that clock. The bench stops the crystal after its last edge and samples the source code both just inside and just outside the 2048-cycle window. A detector that was off by a window, or that never expired, shows up at one of these two sample points. Each source change is checked against the tick strobe and the ready flag in the same cycle. A change that did not wait for a boundary, a flag that was not cleared, or a hold-off that leaked a double strobe would each break that check.

// File: rtl/lfclk_select.sv
module lfclk_select #(
  parameter int unsigned CLK_HZ     = 48_000_000,
  parameter int unsigned TICK_HZ    = 32_768,
  parameter int unsigned MISS_CYC   = 2048,
  parameter int unsigned GOOD_EDGES = 4,
  parameter int unsigned SETTLE_CYC = 4800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en32k,
  input  logic       cfg_xtal_sel,
  input  logic       susclk_in,
  input  logic       xtal_in,
  output logic       tick_o,
  output logic       level_o,
  output logic [1:0] src_o,
  output logic       ready_o
);
  localparam int unsigned AW   = $clog2(CLK_HZ + TICK_HZ);
  localparam int unsigned HALF = CLK_HZ / (2 * TICK_HZ);
  localparam int unsigned GW   = $clog2(MISS_CYC + 1);
  localparam int unsigned EW   = $clog2(GOOD_EDGES + 1);
  localparam int unsigned SW   = $clog2(SETTLE_CYC + 1);
  localparam int unsigned HW   = $clog2(HALF + 1);

  localparam logic [AW-1:0] PH_STEP = AW'(TICK_HZ);
  localparam logic [AW-1:0] PH_LIM  = AW'(CLK_HZ - TICK_HZ);
  localparam logic [GW-1:0] GAP_MAX = GW'(MISS_CYC);
  localparam logic [GW-1:0] GAP_END = GW'(MISS_CYC - 1);
  localparam logic [EW-1:0] GOOD_N  = EW'(GOOD_EDGES);
  localparam logic [EW-1:0] GOOD_L  = EW'(GOOD_EDGES - 1);
  localparam logic [SW-1:0] SET_END = SW'(SETTLE_CYC - 1);
  localparam logic [HW-1:0] HOLD    = HW'(HALF);

  localparam logic [1:0] S_INT = 2'b00;
  localparam logic [1:0] S_SUS = 2'b01;
  localparam logic [1:0] S_XTL = 2'b10;

  logic [1:0] pin_raw, pin_edge, pin_live;
  assign pin_raw = {xtal_in, susclk_in};

  for (genvar i = 0; i < 2; i++) begin : g_det
    logic [2:0]    sh;
    logic [GW-1:0] gap;
    logic [EW-1:0] good;
    logic          live;
    logic          edge_w;

    assign edge_w      = sh[1] & ~sh[2];
    assign pin_edge[i] = edge_w;
    assign pin_live[i] = live;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        gap  <= GAP_MAX;
        good <= '0;
        live <= 1'b0;
      end else begin
        sh <= {sh[1:0], pin_raw[i]};
        if (edge_w) begin
          gap <= '0;
          if (gap < GAP_MAX) begin
            if (good != GOOD_N) good <= good + 1'b1;
            if (good >= GOOD_L) live <= 1'b1;
          end else begin
            good <= EW'(1);
          end
        end else if (gap != GAP_MAX) begin
          gap <= gap + 1'b1;
          if (gap == GAP_END) begin
            live <= 1'b0;
            good <= '0;
          end
        end
      end
    end
  end

  logic [AW-1:0] phase;
  logic          int_tick;
  assign int_tick = phase >= PH_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (int_tick) phase <= phase - PH_LIM;
    else               phase <= phase + PH_STEP;
  end

  logic [1:0]    src_q, want, cand;
  logic          raw_tick, cur_dead, do_switch, tick_d;
  logic [HW-1:0] hold;
  logic [SW-1:0] settle;
  logic          rdy;

  assign want = !cfg_en32k ? S_INT : (cfg_xtal_sel ? S_XTL : S_SUS);
  assign cand = ((want == S_SUS && !pin_live[0]) || (want == S_XTL && !pin_live[1]))
                ? S_INT : want;

  always_comb begin
    case (src_q)
      S_SUS:   raw_tick = pin_edge[0];
      S_XTL:   raw_tick = pin_edge[1];
      default: raw_tick = int_tick;
    endcase
  end

  assign cur_dead  = (src_q == S_SUS && !pin_live[0]) || (src_q == S_XTL && !pin_live[1]);
  assign do_switch = (cand != src_q) && (raw_tick || cur_dead);
  assign tick_d    = raw_tick && (hold == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= S_INT;
      tick_o <= 1'b0;
      hold   <= '0;
      settle <= '0;
      rdy    <= 1'b0;
    end else begin
      tick_o <= tick_d;
      if (tick_d)           hold <= HOLD;
      else if (hold != '0)  hold <= hold - 1'b1;
      if (do_switch) begin
        src_q  <= cand;
        settle <= '0;
        rdy    <= 1'b0;
      end else if (!rdy) begin
        if (settle == SET_END) rdy <= 1'b1;
        else                   settle <= settle + 1'b1;
      end
    end
  end

  assign level_o = hold != '0;
  assign src_o   = src_q;
  assign ready_o = rdy;
endmodule

// File: rtl/lfclk_select_chk.sv
module lfclk_select_chk #(
  parameter int unsigned HALF = 732
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_o,
  input logic       level_o,
  input logic [1:0] src_o,
  input logic       ready_o
);
  int unsigned since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            since <= 32'hFFFF;
    else if (tick_o)       since <= 0;
    else if (since < 32'hFFFF) since <= since + 1;
  end

  // R1
  src_code_chk: assert property (@(posedge clk) disable iff (!rst_n) src_o != 2'b11);
  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n) tick_o |=> !tick_o);
  // R5
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n) tick_o |-> since >= HALF);
  // R6
  level_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) tick_o |-> level_o);
  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(src_o) |-> !ready_o);
  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready_o) |-> $stable(src_o));
endmodule

bind lfclk_select lfclk_select_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_o(tick_o), .level_o(level_o),
  .src_o(src_o), .ready_o(ready_o)
);

// File: tb/lfclk_select_bench.sv
module lfclk_select_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en32k = 1'b0, xsel = 1'b0, sus = 1'b0, xtl = 1'b0;
  logic tick, level, ready;
  logic [1:0] src;

  always #2.5 clk = ~clk;

  lfclk_select u_lfclk_select (
    .clk(clk), .rst_n(rst_n), .cfg_en32k(en32k), .cfg_xtal_sel(xsel),
    .susclk_in(sus), .xtal_in(xtl), .tick_o(tick), .level_o(level),
    .src_o(src), .ready_o(ready)
  );

  int errors = 0, checks = 0;
  int sus_per = 0, xtl_per = 0, sus_ph = 0, xtl_ph = 0;
  longint cyc = 0, last_t = -1, gap = 0, min_gap = 1_000_000;
  int lvl_cnt = 0, lvl_last = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sus_per == 0) begin sus = 0; sus_ph = 0; end
    else begin sus = sus_ph < sus_per / 2; sus_ph = (sus_ph + 1 >= sus_per) ? 0 : sus_ph + 1; end
    if (xtl_per == 0) begin xtl = 0; xtl_ph = 0; end
    else begin xtl = xtl_ph < xtl_per / 2; xtl_ph = (xtl_ph + 1 >= xtl_per) ? 0 : xtl_ph + 1; end
    if (rst_n && tick) begin
      if (last_t >= 0) begin
        gap = cyc - last_t;
        if (gap < min_gap) min_gap = gap;
      end
      last_t = cyc;
      lvl_last = lvl_cnt;
      lvl_cnt = 0;
    end
    if (level) lvl_cnt++;
  end

  task automatic next_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
    #1;
  endtask

  task automatic intervals(input int n, input longint lo, input longint hi, input string req);
    next_tick();
    for (int k = 0; k < n; k++) begin
      next_tick();
      chk(gap >= lo && gap <= hi, req, gap, lo);
      chk(lvl_last == 732, "R6", lvl_last, 732);
    end
  endtask

  task automatic wait_src(input logic [1:0] v, input int lim, output int n);
    n = 0;
    @(negedge clk); #1;
    while (src != v && n < lim) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    int n;
    bit bnd;
    repeat (10) @(negedge clk);
    #1;
    // R10
    chk(tick == 0 && level == 0 && ready == 0 && src == 2'b00, "R10", {tick, level, ready, src}, 0);
    @(negedge clk); rst_n = 1'b1;
    n = 0;
    while (!ready && n < 6000) begin @(negedge clk); #1; n++; end
    // R7 ready after reset release
    chk(n >= 4799 && n <= 4801, "R7", n, 4800);
    // R4 derived tick rate
    intervals(12, 1464, 1465, "R4");

    // R2 edges spaced wider than the window never count
    en32k = 1'b1; xsel = 1'b0; sus_per = 3000;
    repeat (20000) @(negedge clk);
    #1;
    chk(src == 2'b00, "R2", src, 0);

    // R1 suspend pin selected once present
    sus_per = 1465;
    wait_src(2'b01, 12000, n);
    chk(src == 2'b01, "R1", src, 1);
    chk(ready == 0, "R7", ready, 0);
    repeat (4790) @(negedge clk);
    #1;
    chk(ready == 0, "R7", ready, 0);
    repeat (15) @(negedge clk);
    #1;
    chk(ready == 1, "R7", ready, 1);
    // R9 tick follows the pin period
    intervals(6, 1465, 1465, "R9");

    // R1 crystal selected but absent: fall back
    xsel = 1'b1;
    wait_src(2'b00, 3000, n);
    chk(src == 2'b00, "R1", src, 0);
    // R8 boundary change carries a tick
    chk(tick == 1, "R8", tick, 1);
    sus_per = 0;

    xtl_per = 1464;
    wait_src(2'b10, 12000, n);
    chk(src == 2'b10, "R1", src, 2);
    chk(tick == 1, "R8", tick, 1);
    intervals(4, 1464, 1464, "R9");

    en32k = 1'b0;
    wait_src(2'b00, 3000, n);
    chk(src == 2'b00, "R1", src, 0);
    chk(tick == 1, "R8", tick, 1);
    en32k = 1'b1;
    wait_src(2'b10, 3000, n);
    chk(src == 2'b10, "R1", src, 2);

    // R3 crystal stops after its last edge
    next_tick();
    xtl_per = 0;
    repeat (1990) @(negedge clk);
    #1;
    chk(src == 2'b10, "R3", src, 2);
    repeat (120) @(negedge clk);
    #1;
    chk(src == 2'b00, "R3", src, 0);
    intervals(3, 1464, 1465, "R4");

    // R5 minimum tick spacing over the whole run
    chk(min_gap >= 733, "R5", min_gap, 733);
    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 190000) begin @(negedge clk); w++; end
    if (!done) chk(0, "watchdog", w, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule